// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets an 8-bit on-chip master reach asynchronous SRAM-style devices over a narrow pin set. The low address byte and the data byte share one bidirectional bus. The high address byte has its own lines. A latch strobe marks the cycle in which the low address is on the shared bus, so that an external latch can capture it. Active-low read and write strobes then perform the transfer. All strobes are timed from the internal clock, and no clock leaves the block.

The master raises `req_valid` with the direction, the address and the write data. It holds them until `done` pulses. The address space is split into a lower and an upper sector, each with a 2-bit wait code of its own. This lets a slow device and a fast device share the pins. A bus keeper that software can switch on or off repeats the last level seen on the shared bus while nobody drives it.

States: `S_IDLE` (waiting; a valid request moves to `S_ADDR`), `S_ADDR` (latch strobe high, low address driven; always moves to `S_SETUP`), `S_SETUP` (latch strobe low; write data driven or bus released for a read; always moves to `S_STROBE`), `S_STROBE` (read or write strobe low for 1 + extra cycles; moves to `S_HOLD` when the count runs out), `S_HOLD` (strobe high, write data still driven; moves to `S_GAP` for code 3, otherwise to `S_IDLE`), `S_GAP` (bus quiet for one turnaround cycle; moves to `S_IDLE`).

Top module: `xmem_ctrl`

## Requirements
- R1: During and right after reset, `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0 and `done` is 0.
- R2: One cycle after a request is accepted in idle, `ale` is 1 for exactly one cycle. In that cycle `ad_oe` is 1, `ad_out` carries address bits 7:0 and `a_hi` carries address bits 15:8. `a_hi` keeps that value until `done`.
- R3: In a write, `ad_oe` is 1 and `ad_out` equals the write data from the cycle after `ale` up to and including the cycle after `wr_n` returns high. `wr_n` goes low one cycle after `ale` falls.
- R4: In a read, `ad_oe` is 0 from the cycle after `ale` until the end of the access. `rd_n` goes low one cycle after `ale` falls. `rdata` at `done` equals `ad_in` as sampled in the last cycle in which `rd_n` is low.
- R5: The strobe stays low for 1 + E cycles, where E is 0, 1, 2, 2 for wait codes 0, 1, 2, 3. Code 3 also adds one quiet cycle (no strobe, `ad_oe` 0) after the hold cycle and before `done`.
- R6: If address bits 15:13 are below `cfg_boundary`, the access uses `cfg_wait_lo`. Otherwise it uses `cfg_wait_hi`. A boundary of 0 puts the whole space in the upper sector.
- R7: `done` is a one-cycle pulse. Counting the `ale` cycle as 0, it comes in cycle 3+E for codes 0 to 2 and in cycle 4+E for code 3. Between accesses the block spends at least one idle cycle.
- R8: When `cfg_keep_en` is 1 and `ad_oe` is 0, `keep_drive` is 1. When `cfg_keep_en` is 0, or `ad_oe` is 1, `keep_drive` is 0.
- R9: `keep_val` holds the last level on the shared bus. That level is the last value driven on `ad_out` while `ad_oe` was 1, or the read data sampled at the end of a read, whichever came later. It is 0 after reset.
- R10: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read data, valid with done |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_boundary | input | 3 | First upper-sector value of address bits 15:13 |
| cfg_keep_en | input | 1 | Bus keeper enable |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| a_hi | output | 8 | High address lines |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| keep_drive | output | 1 | Keeper is holding the bus |
| keep_val | output | 8 | Level held by the keeper |

## Verification
The bench runs each wait code in both sectors, for both directions, and compares every output on every cycle with a behavioural model. It changes `ad_in` on every strobe cycle, so a design that samples read data one cycle early or late returns the wrong byte. Code 3 is checked against code 2 for the added quiet cycle. A design that drops that cycle, or that adds it to the strobe, moves `done` by one cycle. Addresses just below and at the sector boundary, and a boundary of 0, catch an off-by-one in the comparison. With the keeper on, the bench tracks the held level through a read. A design that updates the held level only from driven data shows a stale value after the read.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_SETUP,
        S_STROBE,
        S_HOLD,
        S_GAP
    } xm_state_t;
endpackage

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel #(
    parameter int ADDR_W = 16,
    parameter int BND_W  = 3,
    parameter int WAIT_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BND_W-1:0]  boundary,
    input  logic [WAIT_W-1:0] wait_lo,
    input  logic [WAIT_W-1:0] wait_hi,
    output logic [WAIT_W-1:0] extra,
    output logic              gap
);
    localparam logic [WAIT_W-1:0] CODE_MAX = {WAIT_W{1'b1}};

    logic [WAIT_W-1:0] code;

    always_comb begin
        code  = (addr[ADDR_W-1 -: BND_W] < boundary) ? wait_lo : wait_hi;
        gap   = (code == CODE_MAX);
        extra = gap ? (code - 1'b1) : code;
    end
endmodule

// File: rtl/xmem_keeper.sv
module xmem_keeper #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bus_oe,
    input  logic [DATA_W-1:0] bus_out,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              sample,
    output logic              keep_drive,
    output logic [DATA_W-1:0] keep_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keep_val <= '0;
        end else if (bus_oe) begin
            keep_val <= bus_out;
        end else if (sample) begin
            keep_val <= bus_in;
        end
    end

    assign keep_drive = en && !bus_oe;

    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe && !sample) |=> $stable(keep_val)); // R9
endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [WAIT_W-1:0]    sel_extra,
    input  logic                 sel_gap,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 sample
);
    xm_state_t          state;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               write_q;
    logic [WAIT_W-1:0]  extra_q;
    logic               gap_q;
    logic [WAIT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            extra_q <= '0;
            gap_q   <= 1'b0;
            cnt     <= '0;
            rdata   <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        state   <= S_ADDR;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        extra_q <= sel_extra;
                        gap_q   <= sel_gap;
                    end
                end
                S_ADDR:  state <= S_SETUP;
                S_SETUP: begin
                    state <= S_STROBE;
                    cnt   <= extra_q;
                end
                S_STROBE: begin
                    if (cnt == '0) begin
                        state <= S_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                    if (sample) begin
                        rdata <= ad_in;
                    end
                end
                S_HOLD:  state <= gap_q ? S_GAP : S_IDLE;
                S_GAP:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        ale    = 1'b0;
        ad_oe  = 1'b0;
        ad_out = wdata_q;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        done   = 1'b0;
        sample = 1'b0;
        a_hi   = addr_q[ADDR_W-1:DATA_W];
        unique case (state)
            S_IDLE: ;
            S_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
            end
            S_SETUP: ad_oe = write_q;
            S_STROBE: begin
                ad_oe  = write_q;
                wr_n   = !write_q;
                rd_n   = write_q;
                sample = !write_q && (cnt == '0);
            end
            S_HOLD: begin
                ad_oe = write_q;
                done  = !gap_q;
            end
            S_GAP:   done = 1'b1;
            default: ;
        endcase
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R10
    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n)); // R10
    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R4
    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe); // R3
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BND_W  = 3,
    parameter int WAIT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    input  logic [WAIT_W-1:0]        cfg_wait_lo,
    input  logic [WAIT_W-1:0]        cfg_wait_hi,
    input  logic [BND_W-1:0]         cfg_boundary,
    input  logic                     cfg_keep_en,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     keep_drive,
    output logic [DATA_W-1:0]        keep_val
);
    logic [WAIT_W-1:0] sel_extra;
    logic              sel_gap;
    logic              sample;

    xmem_sector_sel #(.ADDR_W(ADDR_W), .BND_W(BND_W), .WAIT_W(WAIT_W)) u_sel (
        .addr     (req_addr),
        .boundary (cfg_boundary),
        .wait_lo  (cfg_wait_lo),
        .wait_hi  (cfg_wait_hi),
        .extra    (sel_extra),
        .gap      (sel_gap)
    );

    xmem_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_extra (sel_extra),
        .sel_gap   (sel_gap),
        .ad_in     (ad_in),
        .done      (done),
        .rdata     (rdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .sample    (sample)
    );

    xmem_keeper #(.DATA_W(DATA_W)) u_keep (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_keep_en),
        .bus_oe     (ad_oe),
        .bus_out    (ad_out),
        .bus_in     (ad_in),
        .sample     (sample),
        .keep_drive (keep_drive),
        .keep_val   (keep_val)
    );

    AST_KEEP_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        keep_drive |-> !ad_oe); // R8
endmodule

// File: tb/sim_xmem_ctrl.sv
module sim_xmem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, ad_in = '0;
    logic [1:0]  cfg_wait_lo = '0, cfg_wait_hi = '0;
    logic [2:0]  cfg_boundary = '0;
    logic        cfg_keep_en = 1'b0;
    logic        done, ad_oe, ale, rd_n, wr_n, keep_drive;
    logic [7:0]  rdata, ad_out, a_hi, keep_val;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] model_lvl = '0;

    always #10 clk = ~clk;

    xmem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi),
        .cfg_boundary(cfg_boundary), .cfg_keep_en(cfg_keep_en),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .keep_drive(keep_drive), .keep_val(keep_val)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk_idle();
        chk("R1", "rd_n", rd_n, 1);
        chk("R1", "wr_n", wr_n, 1);
        chk("R1", "ale", ale, 0);
        chk("R1", "ad_oe", ad_oe, 0);
        chk("R7", "done idle", done, 0);
        chk("R8", "keep_drive idle", keep_drive, cfg_keep_en);
        chk("R9", "keep_val idle", keep_val, model_lvl);
    endtask

    // Behavioural model of one access, compared on every cycle
    task automatic access(bit wr, logic [15:0] addr, logic [7:0] wd, logic [7:0] rbase);
        int code, ext, gap, kl, kd;
        code = (addr[15:13] < cfg_boundary) ? cfg_wait_lo : cfg_wait_hi; // R6
        ext  = (code == 3) ? 2 : code;                                   // R5
        gap  = (code == 3) ? 1 : 0;
        kl   = 2 + ext;
        kd   = 3 + ext + gap;                                            // R7
        @(negedge clk);
        chk_idle();
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        for (int k = 0; k <= kd; k++) begin
            bit e_oe, e_rdn, e_wrn;
            logic [7:0] e_out;
            @(negedge clk);
            e_oe  = (k == 0) || (wr && k <= kl + 1);
            e_out = (k == 0) ? addr[7:0] : wd;
            e_rdn = !(!wr && k >= 2 && k <= kl);
            e_wrn = !(wr && k >= 2 && k <= kl);
            chk("R2", "ale", ale, k == 0);
            chk("R2", "a_hi", a_hi, addr[15:8]);
            chk(wr ? "R3" : "R4", "ad_oe", ad_oe, e_oe);
            if (e_oe) chk(k == 0 ? "R2" : "R3", "ad_out", ad_out, e_out);
            chk("R5", "rd_n", rd_n, e_rdn);
            chk("R5", "wr_n", wr_n, e_wrn);
            chk("R10", "strobe excl", (!rd_n && !wr_n) || (ale && (!rd_n || !wr_n)), 0);
            chk("R7", "done", done, k == kd);
            chk("R8", "keep_drive", keep_drive, cfg_keep_en && !e_oe);
            chk("R9", "keep_val", keep_val, model_lvl);
            if (k == kd && !wr) chk("R4", "rdata", rdata, 8'(rbase + kl));
            if (k >= 2 && k <= kl) ad_in = 8'(rbase + k);
            if (e_oe) model_lvl = e_out;
            else if (!wr && k == kl) model_lvl = ad_in;
            if (k == kd) req_valid = 1'b0;
        end
        @(negedge clk);
        chk_idle();
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual hang expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk_idle();                      // R1 in reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle();                      // R1 after reset
        cfg_boundary = 3'd4; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd3; cfg_keep_en = 1'b1;
        // R6 lower sector just below boundary, upper sector at boundary
        access(1, 16'h7FF0, 8'hA5, 8'h00);
        access(1, 16'h8001, 8'h5A, 8'h00);
        access(0, 16'h7F12, 8'h00, 8'h40);
        access(0, 16'h8034, 8'h00, 8'h60);
        // R5 each wait code in both directions
        for (int c = 0; c < 4; c++) begin
            cfg_wait_lo = 2'(c); cfg_wait_hi = 2'(3 - c);
            access(1, 16'h1200 + 16'(c), 8'(8'h10 + c), 8'h00);
            access(0, 16'h3400 + 16'(c), 8'h00, 8'(8'h80 + 16 * c));
            access(0, 16'hE100 + 16'(c), 8'h00, 8'(8'h20 + 16 * c));
        end
        // R6 boundary 0: everything upper
        cfg_boundary = 3'd0; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd2;
        access(0, 16'h0011, 8'h00, 8'hC0);
        // R6 boundary 7: top sector only upper
        cfg_boundary = 3'd7; cfg_wait_lo = 2'd1; cfg_wait_hi = 2'd3;
        access(1, 16'hDFFF, 8'h3C, 8'h00);
        access(0, 16'hE000, 8'h00, 8'h90);
        // R8 keeper disabled
        cfg_keep_en = 1'b0;
        access(0, 16'h0100, 8'h00, 8'hF0);
        access(1, 16'hF0F0, 8'hC3, 8'h00);
        finish_run();
    end
endmodule